// File: doc/BRIEF.md
# I2C Master Receive Controller

This block is the receive side of an I2C bus master. Another part of the interface sends the start condition and the slave address, then pulses `addr_done_i`. From that point this block holds SCL low and waits. Each read of the receive register by software (`rd_i`) releases the bus and starts one word. The block clocks in a programmable number of data bits, most significant bit first. If enabled, it then adds an acknowledge clock. It places the word in `rx_data_o`, pulses `irq_o`, clears `pend_o` and holds SCL low again until the next read.

SCL timing comes from a divider of the system clock: each half period lasts `HALF_CYC` cycles. SDA is sampled in the middle of the SCL high phase. A slave that holds SCL low during the high phase stretches that phase.

To end a transfer, software first clears the acknowledge enable before reading the next-to-last word, so the last word gets no acknowledge clock. It then selects a one-bit word and reads once more. The block gives that single clock with SDA released, which the slave sees as a no-acknowledge, and then generates a stop condition on its own. While the block is waiting, software can also request a stop directly.

Top module: `i2c_mrx_ctrl`

## Requirements
- R1: After reset both line enables are 0 (lines released), `irq_o` is 0, `pend_o` is 1 and `rx_data_o` is 0.
- R2: A pulse on `addr_done_i` while idle makes the block drive SCL low and clear `pend_o`. The pulse has no effect at any other time.
- R3: A read (`rd_i`) while waiting starts a word: `pend_o` goes to 1 and SCL runs with `HALF_CYC` cycles low, then `HALF_CYC` cycles released, for each clock. A read at any other time has no effect.
- R4: The 3-bit `bit_cnt_i` value captured at the read sets the number of data clocks. Codes 1 to 7 give that many clocks and code 0 gives 8.
- R5: SDA is sampled once per data clock, in cycle `HALF_CYC/2` of the high phase. The first bit received is the most significant. At word end `rx_data_o` holds the word in its low bits, with the upper bits zero.
- R6: With `ack_en_i` = 1 at the read, one extra clock follows the data bits, and SDA is driven low through both its low and high phases.
- R7: With `ack_en_i` = 0 at the read, no extra clock follows and SDA is never driven during the word.
- R8: When a word completes, `irq_o` is 1 for exactly one cycle, `pend_o` goes to 0 and SCL stays driven low until the next read.
- R9: A one-bit word read with `ack_en_i` = 0 is followed by a stop sequence, with no wait: `HALF_CYC` cycles with both lines driven low, then `HALF_CYC` cycles with only SDA driven low, then idle with both released and `pend_o` = 1.
- R10: `stop_req_i` while waiting gives the same stop sequence and return to idle. At any other time it has no effect.
- R11: While SCL is released but `scl_i` reads low, the high-phase timing is held, so the high phase is lengthened by the number of stretched cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_done_i | input | 1 | Start and address phase finished (pulse) |
| rd_i | input | 1 | Software read of the receive register (pulse) |
| stop_req_i | input | 1 | Software stop request (pulse) |
| bit_cnt_i | input | 3 | Word length code, 0 means 8 |
| ack_en_i | input | 1 | Add a driven-low acknowledge clock after each word |
| rx_data_o | output | 8 | Receive data register |
| pend_o | output | 1 | 0 while a received word awaits service |
| irq_o | output | 1 | Word complete interrupt request, one cycle |
| scl_oe_o | output | 1 | 1 pulls SCL low |
| scl_i | input | 1 | SCL line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| sda_i | input | 1 | SDA line level |

## Verification
Words are received at lengths 8, 5, 2 and 1, with the acknowledge clock on and off. This separates the length decode, the extra clock and the rule that only a one-bit word with no acknowledge leads to a stop. The data patterns 0xA5, 0x3C and short odd patterns would expose a reversed bit order or a stale upper bit. A stretched first bit shows whether the sample point moves with the stretched high phase. Reads, stop requests and address pulses are also issued while idle and while a word is running. These show that such inputs are ignored, because the reference model predicts every line and flag on every cycle.

// File: rtl/i2c_mrx_pkg.sv
package i2c_mrx_pkg;
  localparam int CODE_W = 3;
  localparam int DATA_W = 8;
  localparam int LEN_W  = $clog2(DATA_W) + 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_LOW,
    ST_HIGH,
    ST_STOP_LO,
    ST_STOP_HI
  } mrx_state_e;

  // code 0 selects a full data-width word
  function automatic logic [LEN_W-1:0] word_len(input logic [CODE_W-1:0] code);
    if (code == '0) return LEN_W'(DATA_W);
    return LEN_W'(code);
  endfunction
endpackage

// File: rtl/i2c_mrx_phase_timer.sv
module i2c_mrx_phase_timer #(
  parameter int HALF_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic at_mid,
  output logic at_end
);
  localparam int CW  = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int MID = HALF_CYC / 2;

  logic [CW-1:0] cnt_q, cnt_d;

  assign at_end = (cnt_q == CW'(HALF_CYC - 1));
  assign at_mid = (cnt_q == CW'(MID));

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (adv) cnt_d = at_end ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2c_mrx_shifter.sv
module i2c_mrx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              bit_in,
  input  logic              load,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] shreg_q, shreg_d, data_q, data_d;

  always_comb begin
    shreg_d = shreg_q;
    if (clr)           shreg_d = '0;
    else if (shift_en) shreg_d = {shreg_q[DATA_W-2:0], bit_in};
    data_d = load ? shreg_d : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      data_q  <= '0;
    end else begin
      shreg_q <= shreg_d;
      data_q  <= data_d;
    end
  end

  assign data_o = data_q;
endmodule

// File: rtl/i2c_mrx_ctrl.sv
module i2c_mrx_ctrl
  import i2c_mrx_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_done_i,
  input  logic              rd_i,
  input  logic              stop_req_i,
  input  logic [CODE_W-1:0] bit_cnt_i,
  input  logic              ack_en_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              pend_o,
  output logic              irq_o,
  output logic              scl_oe_o,
  input  logic              scl_i,
  output logic              sda_oe_o,
  input  logic              sda_i
);
  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  mrx_state_e       state_q, state_d;
  logic [LEN_W-1:0] len_q, len_d, idx_q, idx_d;
  logic             ack_q, ack_d, in_ack_q, in_ack_d;
  logic             irq_q, irq_d, pend_q, pend_d;

  logic at_mid, at_end;
  logic tmr_clr, tmr_adv;
  logic word_start, sample, last_bit, word_done, nack_end;

  assign tmr_clr    = (state_q == ST_IDLE) || (state_q == ST_WAIT);
  assign tmr_adv    = !((state_q == ST_HIGH) && !scl_i);
  assign word_start = (state_q == ST_WAIT) && !stop_req_i && rd_i;
  assign sample     = (state_q == ST_HIGH) && !in_ack_q && at_mid && scl_i;
  assign last_bit   = (idx_q == len_q - LEN_W'(1));
  assign word_done  = (state_q == ST_HIGH) && at_end && scl_i &&
                      (in_ack_q || (last_bit && !ack_q));
  assign nack_end   = word_done && !in_ack_q && (len_q == LEN_W'(1));

  i2c_mrx_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .clr    (tmr_clr),
    .adv    (tmr_adv),
    .at_mid (at_mid),
    .at_end (at_end)
  );

  i2c_mrx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .clr      (word_start),
    .shift_en (sample),
    .bit_in   (sda_i),
    .load     (word_done),
    .data_o   (rx_data_o)
  );

  always_comb begin
    state_d  = state_q;
    len_d    = len_q;
    idx_d    = idx_q;
    ack_d    = ack_q;
    in_ack_d = in_ack_q;
    pend_d   = pend_q;
    irq_d    = word_done;
    case (state_q)
      ST_IDLE: begin
        if (addr_done_i) begin
          state_d = ST_WAIT;
          pend_d  = 1'b0;
        end
      end
      ST_WAIT: begin
        if (stop_req_i) begin
          state_d = ST_STOP_LO;
        end else if (rd_i) begin
          state_d  = ST_LOW;
          len_d    = word_len(bit_cnt_i);
          ack_d    = ack_en_i;
          idx_d    = '0;
          in_ack_d = 1'b0;
          pend_d   = 1'b1;
        end
      end
      ST_LOW: begin
        if (at_end) state_d = ST_HIGH;
      end
      ST_HIGH: begin
        if (at_end && scl_i) begin
          if (word_done) begin
            state_d = nack_end ? ST_STOP_LO : ST_WAIT;
            pend_d  = 1'b0;
          end else begin
            state_d = ST_LOW;
            if (last_bit) in_ack_d = 1'b1;
            else          idx_d    = idx_q + LEN_W'(1);
          end
        end
      end
      ST_STOP_LO: begin
        if (at_end) state_d = ST_STOP_HI;
      end
      ST_STOP_HI: begin
        if (at_end) begin
          state_d = ST_IDLE;
          pend_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      state_q  <= ST_IDLE;
      len_q    <= LEN_W'(DATA_W);
      idx_q    <= '0;
      ack_q    <= 1'b0;
      in_ack_q <= 1'b0;
      irq_q    <= 1'b0;
      pend_q   <= 1'b1;
    end else begin
      state_q  <= state_d;
      len_q    <= len_d;
      idx_q    <= idx_d;
      ack_q    <= ack_d;
      in_ack_q <= in_ack_d;
      irq_q    <= irq_d;
      pend_q   <= pend_d;
    end
  end

  assign scl_oe_o = (state_q == ST_WAIT) || (state_q == ST_LOW) ||
                    (state_q == ST_STOP_LO);
  assign sda_oe_o = (in_ack_q && ((state_q == ST_LOW) || (state_q == ST_HIGH))) ||
                    (state_q == ST_STOP_LO) || (state_q == ST_STOP_HI);
  assign irq_o    = irq_q;
  assign pend_o   = pend_q;
endmodule

// File: rtl/i2c_mrx_ctrl_chk.sv
module i2c_mrx_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic irq_o,
  input logic pend_o,
  input logic scl_oe_o,
  input logic sda_oe_o
);
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  // R8
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (scl_oe_o && !pend_o));

  // R6
  sda_drive_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe_o && !$past(scl_oe_o)) |-> !$rose(sda_oe_o));

  // R9
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe_o && $fell(sda_oe_o)) |-> pend_o);
endmodule

bind i2c_mrx_ctrl i2c_mrx_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_o    (irq_o),
  .pend_o   (pend_o),
  .scl_oe_o (scl_oe_o),
  .sda_oe_o (sda_oe_o)
);

// File: tb/i2c_mrx_ctrl_tb.sv
module i2c_mrx_ctrl_tb;
  localparam int HALF = 4;

  logic       clk;
  logic       rst_n;
  logic       addr_done, rd, stop_req, ack_en;
  logic [2:0] bit_cnt;
  logic [7:0] rx_data;
  logic       pend, irq, scl_oe, sda_oe, scl_in, sda_in;
  logic       slv_bit, stretch;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  assign scl_in = ~scl_oe & ~stretch;
  assign sda_in = ~sda_oe & slv_bit;

  i2c_mrx_ctrl #(.HALF_CYC(HALF)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr_done_i(addr_done), .rd_i(rd),
    .stop_req_i(stop_req), .bit_cnt_i(bit_cnt), .ack_en_i(ack_en),
    .rx_data_o(rx_data), .pend_o(pend), .irq_o(irq),
    .scl_oe_o(scl_oe), .scl_i(scl_in), .sda_oe_o(sda_oe), .sda_i(sda_in)
  );

  typedef struct packed {
    logic       scl;
    logic       sda;
    logic       irq;
    logic       pend;
    logic [7:0] data;
    logic       bitv;
    logic       str;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  exp_t  steady;
  string steady_tag;
  logic [7:0] cur_data;
  int checks, fails;
  bit finished;

  task automatic chk(input logic [7:0] act, input logic [7:0] expv,
                     input string tag, input string what);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, expv, $time);
    end
  endtask

  task automatic push(input logic s, input logic d, input logic i, input logic p,
                      input logic b, input logic st, input string tag);
    exp_t e;
    e.scl = s; e.sda = d; e.irq = i; e.pend = p; e.data = cur_data;
    e.bitv = b; e.str = st;
    q.push_back(e);
    tq.push_back(tag);
    steady = e;
    steady.irq = 1'b0; steady.bitv = 1'b1; steady.str = 1'b0;
    steady_tag = tag;
  endtask

  // per-cycle comparison against the model, away from the clock edge
  always @(posedge clk) begin
    exp_t  e;
    string tg;
    #2;
    if (q.size() > 0) begin
      e  = q.pop_front();
      tg = tq.pop_front();
    end else begin
      e  = steady;
      tg = steady_tag;
    end
    slv_bit = e.bitv;
    stretch = e.str;
    if (!finished) begin
      chk({7'd0, scl_oe}, {7'd0, e.scl}, tg, "scl_oe");
      chk({7'd0, sda_oe}, {7'd0, e.sda}, tg, "sda_oe");
      chk({7'd0, pend},   {7'd0, e.pend}, tg, "pend");
      chk({7'd0, irq},    {7'd0, e.irq}, "R8", "irq");
      chk(rx_data, e.data, "R5", "rx_data");
    end
  end

  task automatic drain();
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic stop_seq(input logic irq_first, input string tag);
    for (int c = 0; c < HALF; c++) push(1, 1, (c == 0) ? irq_first : 1'b0, 0, 1, 0, tag);
    for (int c = 0; c < HALF; c++) push(0, 1, 0, 0, 1, 0, tag);
    push(0, 0, 0, 1, 1, 0, tag);
  endtask

  // expected waveform of one word; val holds the word in its low len bits
  task automatic gen_word(input int len, input bit ack, input logic [7:0] val,
                          input int str_cyc, input string tg);
    for (int b = 0; b < len; b++) begin
      logic bv;
      bv = val[len-1-b];
      for (int c = 0; c < HALF; c++) push(1, 0, 0, 1, bv, 0, tg);
      if (b == 0) for (int c = 0; c < str_cyc; c++) push(0, 0, 0, 1, bv, 1, "R11");
      for (int c = 0; c < HALF; c++) push(0, 0, 0, 1, bv, 0, tg);
    end
    if (ack) begin
      for (int c = 0; c < HALF; c++) push(1, 1, 0, 1, 1, 0, "R6");
      for (int c = 0; c < HALF; c++) push(0, 1, 0, 1, 1, 0, "R6");
    end
    cur_data = val;
    if (len == 1 && !ack) stop_seq(1'b1, "R9");
    else                  push(1, 0, 1, 0, 1, 0, "R8");
  endtask

  task automatic read_word(input logic [2:0] code, input bit ack, input logic [7:0] val,
                           input int str_cyc, input string tg);
    int len;
    len = (code == 3'd0) ? 8 : int'(code);
    @(negedge clk);
    bit_cnt = code; ack_en = ack; rd = 1'b1;
    gen_word(len, ack, val, str_cyc, tg);
    @(negedge clk);
    rd = 1'b0;
    drain();
  endtask

  task automatic addr_pulse();
    @(negedge clk);
    addr_done = 1'b1;
    push(1, 0, 0, 0, 1, 0, "R2");
    @(negedge clk);
    addr_done = 1'b0;
    drain();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    checks = 0; fails = 0; finished = 1'b0;
    rst_n = 1'b0; addr_done = 1'b0; rd = 1'b0; stop_req = 1'b0;
    bit_cnt = 3'd0; ack_en = 1'b1; slv_bit = 1'b1; stretch = 1'b0;
    cur_data = 8'h00;
    steady = '{scl:0, sda:0, irq:0, pend:1, data:8'h00, bitv:1, str:0};
    steady_tag = "R1";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R3 R10 R2: reads and stop requests while idle do nothing
    steady_tag = "R3";
    @(negedge clk); rd = 1'b1; stop_req = 1'b1;
    @(negedge clk); rd = 1'b0; stop_req = 1'b0;
    repeat (4) @(negedge clk);

    addr_pulse();
    // first read only starts reception, full 8-bit word with ack (R4 R5 R6)
    read_word(3'd0, 1'b1, 8'hA5, 0, "R4");

    // R3 R10 R2: pulses during a running word are ignored
    @(negedge clk);
    bit_cnt = 3'd0; ack_en = 1'b1; rd = 1'b1;
    gen_word(8, 1'b1, 8'h3C, 3, "R3");
    @(negedge clk); rd = 1'b0;
    repeat (5) @(negedge clk);
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    repeat (7) @(negedge clk);
    stop_req = 1'b1; @(negedge clk); stop_req = 1'b0;
    repeat (3) @(negedge clk);
    addr_done = 1'b1; @(negedge clk); addr_done = 1'b0;
    drain();

    read_word(3'd5, 1'b1, 8'h16, 0, "R4");
    // R7: no acknowledge, word of 2 then 8 bits, no stop follows
    read_word(3'd2, 1'b0, 8'h02, 0, "R7");
    read_word(3'd0, 1'b0, 8'hC3, 0, "R7");
    // R9: single released clock then automatic stop
    read_word(3'd1, 1'b0, 8'h01, 0, "R9");
    repeat (4) @(negedge clk);

    // R10: new transfer, one word, then stop on request while waiting
    addr_pulse();
    read_word(3'd3, 1'b1, 8'h03, 0, "R4");
    @(negedge clk);
    stop_req = 1'b1; rd = 1'b1;
    stop_seq(1'b0, "R10");
    @(negedge clk);
    stop_req = 1'b0; rd = 1'b0;
    drain();
    repeat (4) @(negedge clk);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule